// File: doc/BRIEF.md
# VGA Raster Timing Generator

This block produces the scan timing for a 640 by 480 display that runs from a 25 MHz pixel clock. A column counter steps on every pixel clock and wraps after 800 clocks, which gives a line of about 32 µs. A row counter advances once per line, at the clock where the horizontal sync interval begins, and wraps after 521 lines, which gives a refresh rate near 60 Hz. Both counts are presented on the ports so that a frame-buffer read address can be formed from them. A frame-start strobe marks the first pixel of each frame.

The sync, display-enable and colour outputs are registered from the counters. They therefore trail `col_o` and `row_o` by one clock, and that clock gives the frame buffer one cycle to return `pixel_i` for the coordinates on the counters. Colour is 12 bits per pixel. Colour is forced to zero, and display-enable is low, whenever the coordinates lie outside the visible window. The horizontal and vertical windows (visible, front porch, sync, back porch) are parameters. Their defaults give the standard 640x480 timing: a line of 640 + 16 + 96 + 48 clocks and a frame of 480 + 10 + 2 + 29 lines.

Top module: `vga_raster_gen`

## Requirements
- R1: `col_o` starts at 0 and increases by one on every clock. After H_TOTAL-1 (799 by default) it returns to 0.
- R2: `row_o` increases by one only on the clock edge at which `col_o` equals H_ACTIVE+H_FRONT (656), which is the first sync column. After V_TOTAL-1 (520) it returns to 0. A frame is 521 lines.
- R3: `hs_o` is active low and registered. It is 0 in exactly the cycles that follow a cycle in which `col_o` lies in [656, 752). Its falling edges are 800 clocks apart, and each low pulse lasts 96 clocks.
- R4: `vs_o` is active low and registered. It is 0 in exactly the cycles that follow a cycle in which `row_o` lies in [490, 492). It stays low across 2 horizontal sync pulses, and its falling edges are 521 lines (416,800 clocks) apart.
- R5: `de_o` is 1 in exactly the cycles that follow a cycle with `col_o` < 640 and `row_o` < 480.
- R6: `rgb_o` equals the `pixel_i` value sampled in the previous cycle when that cycle was visible in the sense of R5. Otherwise `rgb_o` is 0.
- R7: `frame_o` is 1 exactly in the cycle where `col_o` and `row_o` are both 0, which makes it a one-clock pulse per frame.
- R8: While `rst_ni` is low, `col_o` = 0, `row_o` = 0, `hs_o` = 1, `vs_o` = 1, `de_o` = 0, `rgb_o` = 0 and `frame_o` = 1. The first cycle after release shows the first visible pixel of the frame.
- R9: The sync pulses are placed around the visible region as follows. `hs_o` falls 16 clocks after `de_o` falls on a visible line. `de_o` rises 48 clocks after `hs_o` rises. `row_o` reads 490 in the cycle where `vs_o` falls. Exactly 29 `hs_o` falling edges separate the rise of `vs_o` from the first `de_o` rise of the next frame. Neither sync output is ever low while `de_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pixel_i | input | PIX_W (12) | Colour word for the coordinates on col_o/row_o |
| col_o | output | clog2(H_TOTAL) (10) | Current column count |
| row_o | output | clog2(V_TOTAL) (10) | Current row count |
| frame_o | output | 1 | High while both counts are zero |
| hs_o | output | 1 | Horizontal sync, active low |
| vs_o | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Display enable, one clock behind the counts |
| rgb_o | output | PIX_W (12) | Gated colour, one clock behind the counts |

## Verification
The assertions assume only that `rst_ni` is the one thing able to disturb the counters. They make no assumption about `pixel_i`, since the gating has to hold for any colour word. The stimulus therefore drives a new `pixel_i` on every clock, and every word has its top bit set, so a colour that leaks into blanking can never look like the forced zero. Reset is released just after a clock edge and asserted again part-way through a line, so both counters restart from an arbitrary state. A reduced-window instance covers whole frames, and a default-size instance checks the full-length line timing.

// File: rtl/vga_pkg.sv
`timescale 1ns/1ps
package vga_pkg;
  localparam int unsigned RGB_W = 12;

  typedef struct packed {
    logic hs_n;
    logic vs_n;
    logic de;
  } sync_t;

  localparam sync_t SYNC_IDLE = '{hs_n: 1'b1, vs_n: 1'b1, de: 1'b0};

  function automatic logic in_span(input int unsigned val,
                                   input int unsigned start,
                                   input int unsigned len);
    return (val >= start) && (val < start + len);
  endfunction
endpackage

// File: rtl/vga_axis_counter.sv
`timescale 1ns/1ps
module vga_axis_counter #(
  parameter int unsigned TOTAL = 800,
  parameter int unsigned W     = $clog2(TOTAL)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] cnt_o
);
  logic at_end;
  assign at_end = (cnt_o == W'(TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (step_i) cnt_o <= at_end ? '0 : cnt_o + W'(1);
  end
endmodule

// File: rtl/vga_span_dec.sv
`timescale 1ns/1ps
module vga_span_dec #(
  parameter int unsigned W     = 10,
  parameter int unsigned START = 0,
  parameter int unsigned LEN   = 1
) (
  input  logic [W-1:0] cnt_i,
  output logic         in_o
);
  assign in_o = vga_pkg::in_span(32'(cnt_i), START, LEN);
endmodule

// File: rtl/vga_video_out.sv
`timescale 1ns/1ps
module vga_video_out #(
  parameter int unsigned PIX_W = vga_pkg::RGB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_win_i,
  input  logic             vs_win_i,
  input  logic             vis_i,
  input  logic [PIX_W-1:0] pixel_i,
  output logic             hs_o,
  output logic             vs_o,
  output logic             de_o,
  output logic [PIX_W-1:0] rgb_o
);
  vga_pkg::sync_t   sync_q;
  logic [PIX_W-1:0] rgb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= vga_pkg::SYNC_IDLE;
      rgb_q  <= '0;
    end else begin
      sync_q.hs_n <= ~hs_win_i;
      sync_q.vs_n <= ~vs_win_i;
      sync_q.de   <= vis_i;
      rgb_q       <= vis_i ? pixel_i : '0;  // blank outside window
    end
  end

  assign hs_o  = sync_q.hs_n;
  assign vs_o  = sync_q.vs_n;
  assign de_o  = sync_q.de;
  assign rgb_o = rgb_q;
endmodule

// File: rtl/vga_raster_gen.sv
`timescale 1ns/1ps
module vga_raster_gen #(
  parameter  int unsigned H_ACTIVE = 640,
  parameter  int unsigned H_FRONT  = 16,
  parameter  int unsigned H_SYNC   = 96,
  parameter  int unsigned H_BACK   = 48,
  parameter  int unsigned V_ACTIVE = 480,
  parameter  int unsigned V_FRONT  = 10,
  parameter  int unsigned V_SYNC   = 2,
  parameter  int unsigned V_BACK   = 29,
  parameter  int unsigned PIX_W    = vga_pkg::RGB_W,
  localparam int unsigned H_TOTAL  = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
  localparam int unsigned V_TOTAL  = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
  localparam int unsigned HW       = $clog2(H_TOTAL),
  localparam int unsigned VW       = $clog2(V_TOTAL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pixel_i,
  output logic [HW-1:0]    col_o,
  output logic [VW-1:0]    row_o,
  output logic             frame_o,
  output logic             hs_o,
  output logic             vs_o,
  output logic             de_o,
  output logic [PIX_W-1:0] rgb_o
);
  localparam int unsigned HS_START = H_ACTIVE + H_FRONT;
  localparam int unsigned VS_START = V_ACTIVE + V_FRONT;

  logic line_step;
  logic h_vis, v_vis, h_sync_win, v_sync_win;

  // row advances on the hsync event, not on the line wrap
  assign line_step = (col_o == HW'(HS_START));

  vga_axis_counter #(.TOTAL(H_TOTAL), .W(HW)) u_hcnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(1'b1),
    .cnt_o (col_o)
  );

  vga_axis_counter #(.TOTAL(V_TOTAL), .W(VW)) u_vcnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(line_step),
    .cnt_o (row_o)
  );

  vga_span_dec #(.W(HW), .START(0), .LEN(H_ACTIVE)) u_hvis (
    .cnt_i(col_o), .in_o(h_vis)
  );
  vga_span_dec #(.W(VW), .START(0), .LEN(V_ACTIVE)) u_vvis (
    .cnt_i(row_o), .in_o(v_vis)
  );
  vga_span_dec #(.W(HW), .START(HS_START), .LEN(H_SYNC)) u_hsw (
    .cnt_i(col_o), .in_o(h_sync_win)
  );
  vga_span_dec #(.W(VW), .START(VS_START), .LEN(V_SYNC)) u_vsw (
    .cnt_i(row_o), .in_o(v_sync_win)
  );

  vga_video_out #(.PIX_W(PIX_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hs_win_i(h_sync_win),
    .vs_win_i(v_sync_win),
    .vis_i   (h_vis & v_vis),
    .pixel_i (pixel_i),
    .hs_o    (hs_o),
    .vs_o    (vs_o),
    .de_o    (de_o),
    .rgb_o   (rgb_o)
  );

  assign frame_o = (col_o == '0) && (row_o == '0);
endmodule

// File: rtl/vga_raster_chk.sv
`timescale 1ns/1ps
module vga_raster_chk #(
  parameter  int unsigned H_ACTIVE = 640,
  parameter  int unsigned H_FRONT  = 16,
  parameter  int unsigned H_SYNC   = 96,
  parameter  int unsigned H_BACK   = 48,
  parameter  int unsigned V_ACTIVE = 480,
  parameter  int unsigned V_FRONT  = 10,
  parameter  int unsigned V_SYNC   = 2,
  parameter  int unsigned V_BACK   = 29,
  parameter  int unsigned PIX_W    = vga_pkg::RGB_W,
  localparam int unsigned H_TOTAL  = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
  localparam int unsigned V_TOTAL  = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
  localparam int unsigned HW       = $clog2(H_TOTAL),
  localparam int unsigned VW       = $clog2(V_TOTAL)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [HW-1:0]    col_o,
  input logic [VW-1:0]    row_o,
  input logic             frame_o,
  input logic             hs_o,
  input logic             vs_o,
  input logic             de_o,
  input logic [PIX_W-1:0] rgb_o
);
  localparam int unsigned HS_START = H_ACTIVE + H_FRONT;

  logic        past_ok;
  logic [HW:0] hs_lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok   <= 1'b0;
      hs_lo_cnt <= '0;
    end else begin
      past_ok   <= 1'b1;
      hs_lo_cnt <= hs_o ? '0 : hs_lo_cnt + (HW+1)'(1);
    end
  end

  AST_COL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> 32'(col_o) == ((32'($past(col_o)) == H_TOTAL - 1) ? 0 : 32'($past(col_o)) + 1)); // R1
  AST_ROW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && (row_o != $past(row_o)) |-> 32'($past(col_o)) == HS_START); // R2
  AST_ROW_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && 32'($past(col_o)) == HS_START && 32'($past(row_o)) == V_TOTAL - 1 |-> row_o == '0); // R2
  AST_ROW_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(row_o) < V_TOTAL); // R2
  AST_HS_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_o) |-> 32'(hs_lo_cnt) == H_SYNC); // R3
  AST_VS_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vs_o |-> !de_o); // R4
  AST_DE_VIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && 32'($past(col_o)) < H_ACTIVE && 32'($past(row_o)) < V_ACTIVE |-> de_o); // R5
  AST_RGB_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !(32'($past(col_o)) < H_ACTIVE && 32'($past(row_o)) < V_ACTIVE) |-> !de_o && rgb_o == '0); // R6
  AST_FRAME_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o); // R7
  AST_HS_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs_o |-> !de_o); // R9
endmodule

bind vga_raster_gen vga_raster_chk #(
  .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
  .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
  .PIX_W(PIX_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .col_o(col_o), .row_o(row_o),
  .frame_o(frame_o), .hs_o(hs_o), .vs_o(vs_o), .de_o(de_o), .rgb_o(rgb_o)
);

// File: tb/vga_raster_gen_tb.sv
`timescale 1ns/1ps
module vga_raster_gen_tb;
  // reduced windows so whole frames fit in the run
  localparam int HA = 16, HF = 2, HS = 3, HB = 4;
  localparam int VA = 6,  VF = 1, VS = 2, VB = 3;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int HSS = HA + HF;

  typedef struct {
    int col; int row; int hs; int vs; int de; int rgb; int frame;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] pixel_i = '0;
  logic [4:0]  col_o;
  logic [3:0]  row_o;
  logic        frame_o, hs_o, vs_o, de_o;
  logic [11:0] rgb_o;

  logic [9:0]  f_col, f_row;
  logic        f_frame, f_hs, f_vs, f_de;
  logic [11:0] f_rgb;

  int n_chk = 0;
  int n_fail = 0;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  vga_raster_gen #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pixel_i(pixel_i),
    .col_o(col_o), .row_o(row_o), .frame_o(frame_o),
    .hs_o(hs_o), .vs_o(vs_o), .de_o(de_o), .rgb_o(rgb_o)
  );

  vga_raster_gen u_dut_full (
    .clk_i(clk), .rst_ni(rst_ni), .pixel_i(12'habc),
    .col_o(f_col), .row_o(f_row), .frame_o(f_frame),
    .hs_o(f_hs), .vs_o(f_vs), .de_o(f_de), .rgb_o(f_rgb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int h_of(input int n);
    return n % HT;
  endfunction
  function automatic int v_of(input int n);
    return ((n + HT - HSS - 1) / HT) % VT;
  endfunction
  function automatic int pix_of(input int n);
    return 'h800 | ((n * 37) & 'h7ff);
  endfunction

  function automatic exp_t item_of(input int k);
    exp_t e;
    int hp, vp, vis;
    if (k == 0) begin
      e = '{0, 0, 1, 1, 0, 0, 1};
    end else begin
      hp = h_of(k - 1);
      vp = v_of(k - 1);
      vis = (hp < HA && vp < VA) ? 1 : 0;
      e.col = h_of(k);
      e.row = v_of(k);
      e.hs = (hp >= HSS && hp < HSS + HS) ? 0 : 1;
      e.vs = (vp >= VA + VF && vp < VA + VF + VS) ? 0 : 1;
      e.de = vis;
      e.rgb = vis ? pix_of(k - 1) : 0;
      e.frame = (h_of(k) == 0 && v_of(k) == 0) ? 1 : 0;
    end
    return e;
  endfunction

  task automatic reset_checks();
    chk("R8 col_o in reset", int'(col_o), 0);
    chk("R8 row_o in reset", int'(row_o), 0);
    chk("R8 hs_o in reset", int'(hs_o), 1);
    chk("R8 vs_o in reset", int'(vs_o), 1);
    chk("R8 de_o in reset", int'(de_o), 0);
    chk("R8 rgb_o in reset", int'(rgb_o), 0);
    chk("R8 frame_o in reset", int'(frame_o), 1);
  endtask

  // driver: queues expected items one cycle ahead of the monitor
  task automatic run_phase(input int n);
    sb_q.delete();
    sb_q.push_back(item_of(0));
    sb_q.push_back(item_of(1));
    pixel_i = 12'(pix_of(0));
    rst_ni = 1'b1;
    for (int j = 1; j < n; j++) begin
      @(posedge clk); #1;
      pixel_i = 12'(pix_of(j));
      sb_q.push_back(item_of(j + 1));
    end
  endtask

  // monitor for the reduced instance
  int cyc, hs_fall_t, hs_rise_t, de_fall_t, vs_fall_t;
  int lines_in_frame, vs_lines, bp_cnt;
  bit bp_arm, p_hs, p_vs, p_de;

  always @(negedge clk) begin
    exp_t it;
    if (!rst_ni) begin
      cyc = 0; hs_fall_t = -1; hs_rise_t = -1; de_fall_t = -1; vs_fall_t = -1;
      lines_in_frame = 0; vs_lines = 0; bp_cnt = 0; bp_arm = 0;
      p_hs = 1; p_vs = 1; p_de = 0;
    end else begin
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        chk("R1 col_o", int'(col_o), it.col);
        chk("R2 row_o", int'(row_o), it.row);
        chk("R3 hs_o", int'(hs_o), it.hs);
        chk("R4 vs_o", int'(vs_o), it.vs);
        chk("R5 de_o", int'(de_o), it.de);
        chk("R6 rgb_o", int'(rgb_o), it.rgb);
        chk("R7 frame_o", int'(frame_o), it.frame);
      end
      if (p_hs && !hs_o) begin
        if (hs_fall_t >= 0) chk("R3 hs period", cyc - hs_fall_t, HT);
        if (de_fall_t >= 0 && cyc - de_fall_t < HT) chk("R9 h front porch", cyc - de_fall_t, HF);
        hs_fall_t = cyc;
        lines_in_frame++;
        if (!vs_o) vs_lines++;
        if (bp_arm) bp_cnt++;
      end
      if (!p_hs && hs_o) begin
        if (hs_fall_t >= 0) chk("R3 hs width", cyc - hs_fall_t, HS);
        hs_rise_t = cyc;
      end
      if (p_de && !de_o) de_fall_t = cyc;
      if (!p_de && de_o) begin
        if (hs_rise_t >= 0 && cyc - hs_rise_t < HT) chk("R9 h back porch", cyc - hs_rise_t, HB);
        if (bp_arm) begin
          chk("R9 v back porch lines", bp_cnt, VB);
          bp_arm = 0;
        end
      end
      if (p_vs && !vs_o) begin
        if (vs_fall_t >= 0) begin
          chk("R4 vs period clocks", cyc - vs_fall_t, HT * VT);
          chk("R4 vs period lines", lines_in_frame, VT);
        end
        chk("R9 row at vs start", int'(row_o), VA + VF);
        vs_fall_t = cyc;
        lines_in_frame = 0;
        vs_lines = 0;
      end
      if (!p_vs && vs_o) begin
        chk("R4 vs width lines", vs_lines, VS);
        bp_arm = 1;
        bp_cnt = 0;
      end
      p_hs = hs_o; p_vs = vs_o; p_de = de_o;
      cyc++;
    end
  end

  // monitor for the default-size instance (line timing only)
  int f_cyc, f_hs_fall, f_hs_rise, f_de_fall, f_lines;
  bit f_phs, f_pde;

  always @(negedge clk) begin
    if (!rst_ni) begin
      f_cyc = 0; f_hs_fall = -1; f_hs_rise = -1; f_de_fall = -1; f_lines = 0;
      f_phs = 1; f_pde = 0;
    end else begin
      if (f_phs && !f_hs) begin
        f_lines++;
        if (f_hs_fall >= 0) chk("R3 full hs period", f_cyc - f_hs_fall, 800);
        if (f_de_fall >= 0) chk("R9 full h front porch", f_cyc - f_de_fall, 16);
        chk("R1 full col at hs fall", int'(f_col), 657);
        chk("R2 full row after hsync", int'(f_row), f_lines);
        f_hs_fall = f_cyc;
      end
      if (!f_phs && f_hs) begin
        chk("R3 full hs width", f_cyc - f_hs_fall, 96);
        f_hs_rise = f_cyc;
      end
      if (f_pde && !f_de) f_de_fall = f_cyc;
      if (!f_pde && f_de && f_hs_rise >= 0) chk("R9 full h back porch", f_cyc - f_hs_rise, 48);
      f_phs = f_hs; f_pde = f_de;
      f_cyc++;
    end
  end

  initial begin
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    reset_checks();
    run_phase(3013);
    @(posedge clk); #1;
    rst_ni = 1'b0;  // mid-line reset
    @(posedge clk); #1;
    reset_checks();
    run_phase(700);
    @(posedge clk); #1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule